// File: doc/BRIEF.md
# Edge and Level Interrupt Pending Logic

This block holds the pending, enable, trigger-mode and recorded-line state for a bank of shared peripheral interrupts. The bank covers interrupt numbers from 32 upward. Raw interrupt lines enter through a two-stage synchroniser. The synchronised value is compared with the level recorded for that line, so only a change of level counts as an event. Interrupts set to edge mode latch a pending flag on a rising transition. Interrupts set to level mode read as pending for as long as their recorded line level is high, and they can also hold a latched flag.

Software reaches the state through a byte-wide write port and a combinational byte-wide read port. The write port sets and clears enables, sets and clears pending flags, and programs the trigger mode. The acknowledge logic sends a clear strobe with an interrupt index. The completion logic sends an end-of-service strobe, which latches an enabled level source again if its line is still high. The arbiter receives the raw pending vector and a request vector, which is pending masked by enable.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset every pending flag, enable and mode bit is zero (all level mode), so pend_o, request_o and every register read return zero.
- R2: A raw line passes two synchroniser flops before transition detection, so an edge-mode rise shows on pend_o on the third rising clock edge after it is applied. A line that stays high creates no new event after its flag is cleared.
- R3: In edge mode (mode bit 1) a rising recorded transition latches pending, and the flag stays set after the line falls until it is cleared.
- R4: In level mode (mode bit 0) the interrupt reads as pending while its recorded level is high, and stops reading as pending once the line falls, unless a latched flag remains.
- R5: An acknowledge strobe for an index clears its latched flag in both modes. A level source whose line is still high keeps reading as pending.
- R6: Writing byte 0x100 + id/8 sets the enable for each data bit id%8 that is 1. Writing byte 0x180 + id/8 clears it the same way. Zero bits leave enables unchanged, and reads of either byte return the enables.
- R7: A set-enable write to a level-mode interrupt whose recorded level is high latches its pending flag.
- R8: Writing byte 0x200 + id/8 sets pending flags and writing byte 0x280 + id/8 clears them, in both cases for the 1 bits. Reads of either byte return pending state.
- R9: Mode byte 0xC00 + id/4 holds the edge bit of interrupt id at bit 2*(id%4)+1, and the other field bit reads as zero. Accesses for ids below 32 are ignored and read zero, and so are accesses for ids at or beyond 32 + NUM_IRQ.
- R10: A completion strobe for an enabled level-mode interrupt whose recorded level is high latches its pending flag again.
- R11: When a set request and a clear request reach the same flag in one cycle, the set wins.
- R12: request_o is high exactly for interrupts that are both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | NUM_IRQ | Raw interrupt lines, bit i is id 32+i |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_addr_i | input | 12 | Write byte address |
| wr_data_i | input | 8 | Write byte data |
| rd_addr_i | input | 12 | Read byte address |
| rd_data_o | output | 8 | Read byte data (combinational) |
| ack_valid_i | input | 1 | Acknowledge clear strobe |
| ack_idx_i | input | IDXW | Local index being acknowledged |
| eoi_valid_i | input | 1 | Completion strobe |
| eoi_idx_i | input | IDXW | Local index being completed |
| pend_o | output | NUM_IRQ | Pending state per interrupt |
| request_o | output | NUM_IRQ | Pending and enabled per interrupt |

## Verification
The bench first applies a sequence of register writes, each followed by a read-back. This sequence separates write-1 from write-0 behaviour, enable state from pending state, the stored edge bit from the discarded field bit, and addresses that are implemented from those that are not. Directed line patterns come next. A rise held high and then acknowledged separates edge latching from transition-only detection. The same pattern on a level-mode source shows the live-line term outliving the acknowledge. The line-high-before-enable case and the completion-versus-no-completion pair separate the two re-latch paths from plain level tracking. The set-pending write that arrives together with an acknowledge exposes which request wins.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int unsigned FIRST_SHARED_ID = 32;
    localparam int unsigned ADDR_W          = 12;

    localparam logic [ADDR_W-1:0] SET_EN_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] CLR_EN_BASE = 12'h180;
    localparam logic [ADDR_W-1:0] SET_PD_BASE = 12'h200;
    localparam logic [ADDR_W-1:0] CLR_PD_BASE = 12'h280;
    localparam logic [ADDR_W-1:0] MODE_BASE   = 12'hC00;

    // Per-interrupt write strobes produced by the register port
    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic set_pd;
        logic clr_pd;
        logic mode_wr;
        logic mode_edge;
    } irq_wr_t;

    // Byte holding one bit per interrupt
    function automatic logic [ADDR_W-1:0] bit_reg_addr(logic [ADDR_W-1:0] base, int unsigned id);
        return base + ADDR_W'(id >> 3);
    endfunction

    // Byte holding a 2-bit field per interrupt
    function automatic logic [ADDR_W-1:0] mode_reg_addr(int unsigned id);
        return MODE_BASE + ADDR_W'(id >> 2);
    endfunction

    function automatic int unsigned bit_pos(int unsigned id);
        return id & 7;
    endfunction

    function automatic int unsigned edge_pos(int unsigned id);
        return 2 * (id & 3) + 1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] edge_i,
    output irq_wr_t [NUM_IRQ-1:0] wr_o
);
    for (genvar i = 0; i < int'(NUM_IRQ); i++) begin : g_wr
        localparam int unsigned ID = FIRST_SHARED_ID + i;
        localparam int unsigned BP = bit_pos(ID);
        localparam int unsigned EP = edge_pos(ID);
        always_comb begin
            wr_o[i].set_en    = wr_en_i && (wr_addr_i == bit_reg_addr(SET_EN_BASE, ID)) && wr_data_i[BP];
            wr_o[i].clr_en    = wr_en_i && (wr_addr_i == bit_reg_addr(CLR_EN_BASE, ID)) && wr_data_i[BP];
            wr_o[i].set_pd    = wr_en_i && (wr_addr_i == bit_reg_addr(SET_PD_BASE, ID)) && wr_data_i[BP];
            wr_o[i].clr_pd    = wr_en_i && (wr_addr_i == bit_reg_addr(CLR_PD_BASE, ID)) && wr_data_i[BP];
            wr_o[i].mode_wr   = wr_en_i && (wr_addr_i == mode_reg_addr(ID));
            wr_o[i].mode_edge = wr_data_i[EP];
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            if (rd_addr_i == bit_reg_addr(SET_EN_BASE, FIRST_SHARED_ID + i) ||
                rd_addr_i == bit_reg_addr(CLR_EN_BASE, FIRST_SHARED_ID + i))
                rd_data_o[3'(bit_pos(FIRST_SHARED_ID + i))] = en_i[i];
            if (rd_addr_i == bit_reg_addr(SET_PD_BASE, FIRST_SHARED_ID + i) ||
                rd_addr_i == bit_reg_addr(CLR_PD_BASE, FIRST_SHARED_ID + i))
                rd_data_o[3'(bit_pos(FIRST_SHARED_ID + i))] = pend_i[i];
            if (rd_addr_i == mode_reg_addr(FIRST_SHARED_ID + i))
                rd_data_o[3'(edge_pos(FIRST_SHARED_ID + i))] = edge_i[i];
        end
    end
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
    import irq_pend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line_i,
    input  irq_wr_t wr_i,
    input  logic    ack_i,
    input  logic    eoi_i,
    output logic    pend_o,
    output logic    en_o,
    output logic    edge_o
);
    logic rec_q, latch_q, en_q, edge_q;
    logic rise, set_req, clr_req;

    assign rise    = line_i && !rec_q;
    assign set_req = (edge_q && rise)
                   || wr_i.set_pd
                   || (wr_i.set_en && !edge_q && rec_q)
                   || (eoi_i && en_q && !edge_q && rec_q);
    assign clr_req = wr_i.clr_pd || ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q   <= 1'b0;
            latch_q <= 1'b0;
            en_q    <= 1'b0;
            edge_q  <= 1'b0;
        end else begin
            if (line_i != rec_q) rec_q <= line_i;
            latch_q <= (latch_q && !clr_req) || set_req;
            en_q    <= (en_q && !wr_i.clr_en) || wr_i.set_en;
            if (wr_i.mode_wr) edge_q <= wr_i.mode_edge;
        end
    end

    assign pend_o = latch_q || (!edge_q && rec_q);
    assign en_o   = en_q;
    assign edge_o = edge_q;

    assert_edge_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (edge_q && line_i && !rec_q) |=> pend_o);
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        wr_i.set_pd |=> pend_o);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !line_i && !wr_i.set_pd && !wr_i.set_en && !wr_i.mode_wr && !eoi_i) |=> !pend_o);
    assert_set_enable_R6: assert property (@(posedge clk) disable iff (rst)
        wr_i.set_en |=> en_o);
    assert_clr_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_i.clr_en && !wr_i.set_en) |=> !en_o);
    assert_enable_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_i.set_en && !edge_q && rec_q) |=> pend_o);
    assert_eoi_relatch_R10: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && en_q && !edge_q && rec_q) |=> pend_o);
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 32,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDXW       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_line_i,
    input  logic               wr_en_i,
    input  logic [11:0]        wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  logic [11:0]        rd_addr_i,
    output logic [7:0]         rd_data_o,
    input  logic               ack_valid_i,
    input  logic [IDXW-1:0]    ack_idx_i,
    input  logic               eoi_valid_i,
    input  logic [IDXW-1:0]    eoi_idx_i,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] request_o
);
    logic [NUM_IRQ-1:0] line_sync, en_vec, edge_vec;
    irq_wr_t [NUM_IRQ-1:0] wr_vec;

    irq_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_line_i),
        .q_o (line_sync)
    );

    irq_reg_port #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .en_i      (en_vec),
        .pend_i    (pend_o),
        .edge_i    (edge_vec),
        .wr_o      (wr_vec)
    );

    for (genvar i = 0; i < int'(NUM_IRQ); i++) begin : g_cell
        irq_pend_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .line_i (line_sync[i]),
            .wr_i   (wr_vec[i]),
            .ack_i  (ack_valid_i && (ack_idx_i == IDXW'(i))),
            .eoi_i  (eoi_valid_i && (eoi_idx_i == IDXW'(i))),
            .pend_o (pend_o[i]),
            .en_o   (en_vec[i]),
            .edge_o (edge_vec[i])
        );
    end

    assign request_o = pend_o & en_vec;
endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_line = '0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [11:0]   rd_addr = '0;
    logic [7:0]    rd_data;
    logic          ack_valid = 1'b0;
    logic [4:0]    ack_idx = '0;
    logic          eoi_valid = 1'b0;
    logic [4:0]    eoi_idx = '0;
    logic [N-1:0]  pend, request;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    irq_pend_ctrl #(.NUM_IRQ(N)) u_dut (
        .clk(clk), .rst(rst), .irq_line_i(irq_line),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ack_valid_i(ack_valid), .ack_idx_i(ack_idx),
        .eoi_valid_i(eoi_valid), .eoi_idx_i(eoi_idx),
        .pend_o(pend), .request_o(request)
    );

    // write addr, write data, read addr, expected read, requirement number
    localparam logic [43:0] TBL [12] = '{
        {12'h104, 8'h0F, 12'h104, 8'h0F, 4'd6},  // R6 set enables ids 32..35
        {12'h104, 8'h00, 12'h104, 8'h0F, 4'd6},  // R6 zero bits no effect
        {12'h184, 8'h03, 12'h104, 8'h0C, 4'd6},  // R6 clear ids 32,33
        {12'h184, 8'h00, 12'h184, 8'h0C, 4'd6},  // R6 clear byte reads enables
        {12'h207, 8'h81, 12'h207, 8'h81, 4'd8},  // R8 set pending ids 56,63
        {12'h287, 8'h01, 12'h287, 8'h80, 4'd8},  // R8 clear id 56
        {12'h287, 8'h80, 12'h207, 8'h00, 4'd8},  // R8 clear id 63
        {12'hC08, 8'hAA, 12'hC08, 8'hAA, 4'd9},  // R9 edge bits ids 32..35
        {12'hC08, 8'h55, 12'hC08, 8'h00, 4'd9},  // R9 other field bit dropped
        {12'hC00, 8'hFF, 12'hC00, 8'h00, 4'd9},  // R9 ids below 32 ignored
        {12'h100, 8'hFF, 12'h100, 8'h00, 4'd9},  // R9 ids below 32 enable
        {12'h108, 8'hFF, 12'h108, 8'h00, 4'd9}   // R9 ids beyond count
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ack(input int idx);
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = 5'(idx);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic eoi(input int idx);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_idx = 5'(idx);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        do_reset();

        // R1 reset state
        chk("R1 pend", 32'(pend), 32'h0);
        chk("R1 request", 32'(request), 32'h0);
        rd(12'h104, r); chk("R1 enable read", 32'(r), 32'h0);
        rd(12'hC08, r); chk("R1 mode read", 32'(r), 32'h0);

        // Register table walk
        for (int t = 0; t < 12; t++) begin
            wr(TBL[t][43:32], TBL[t][31:24]);
            rd(TBL[t][23:12], r);
            chk($sformatf("R%0d table row %0d", TBL[t][3:0], t), 32'(r), 32'(TBL[t][11:4]));
        end

        do_reset();

        // R2 synchroniser latency and R3 edge latch on id 32 (local 0)
        wr(12'hC08, 8'h02);
        @(negedge clk); irq_line[0] = 1'b1;
        wait_n(2);
        chk("R2 not yet after two edges", 32'(pend[0]), 32'h0);
        wait_n(1);
        chk("R2 visible on third edge", 32'(pend[0]), 32'h1);
        irq_line[0] = 1'b0;
        wait_n(4);
        chk("R3 edge flag held after line falls", 32'(pend[0]), 32'h1);
        ack(0);
        chk("R5 ack clears edge flag", 32'(pend[0]), 32'h0);
        irq_line[0] = 1'b1;
        wait_n(4);
        chk("R3 second rise latches", 32'(pend[0]), 32'h1);
        ack(0);
        wait_n(4);
        chk("R2 steady high no new event", 32'(pend[0]), 32'h0);

        // R4 level tracking on id 33 (local 1), not enabled
        irq_line[1] = 1'b1;
        wait_n(4);
        chk("R4 level high pending", 32'(pend[1]), 32'h1);
        chk("R12 not enabled no request", 32'(request[1]), 32'h0);
        ack(1);
        chk("R5 level still pending after ack", 32'(pend[1]), 32'h1);
        irq_line[1] = 1'b0;
        wait_n(4);
        chk("R4 level low not pending", 32'(pend[1]), 32'h0);

        // R7 enable with line already high, id 34 (local 2)
        irq_line[2] = 1'b1;
        wait_n(4);
        wr(12'h104, 8'h04);
        irq_line[2] = 1'b0;
        wait_n(4);
        chk("R7 enable latches level source", 32'(pend[2]), 32'h1);
        chk("R12 pending and enabled requests", 32'(request[2]), 32'h1);
        ack(2);
        chk("R5 ack clears latched level", 32'(pend[2]), 32'h0);

        // R10 completion re-latch on id 35 (local 3), control on id 36 (local 4)
        wr(12'h104, 8'h18);
        irq_line[3] = 1'b1;
        irq_line[4] = 1'b1;
        wait_n(4);
        ack(3);
        ack(4);
        eoi(3);
        irq_line[3] = 1'b0;
        irq_line[4] = 1'b0;
        wait_n(4);
        chk("R10 completion re-latches", 32'(pend[3]), 32'h1);
        chk("R10 control without completion", 32'(pend[4]), 32'h0);

        // R11 set-pending write and acknowledge in one cycle, id 37 (local 5)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h204; wr_data = 8'h20;
        ack_valid = 1'b1; ack_idx = 5'd5;
        @(negedge clk);
        wr_en = 1'b0; ack_valid = 1'b0;
        chk("R11 set wins over clear", 32'(pend[5]), 32'h1);
        rd(12'h284, r);
        chk("R8 clear byte reads pending", 32'(r), 32'h28);
        chk("R12 request vector", 32'(request), 32'h0000_0008);

        finish_run();
    end
endmodule